// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects interrupt events from eleven leaf groups and reduces them into one master register that drives a single message request. Every leaf group has four 32-bit registers. The status register shows the raw event inputs. The mask register decides which events get captured. The identity register holds the captured events and is cleared by writing ones. The enable register chooses which captured events count as pending.

A fixed routing table maps each group's pending bits, or one half of them, onto a summary bit of the master register. The top bit of the master register is a global enable and is the only bit software can write. The request output pulses for one cycle when three conditions become true together: the global enable is on, at least one summary bit is set, and the message-control word is in its only supported form.

Software uses one 32-bit register port. A write is a single cycle with `wr_en` high. Reads are combinational from `addr` and have no side effects. Each event source drives its own bit of `ev_in`, and that bit is sampled on every clock edge.

Top module: `irq_aggregator`

## Requirements
- R1: Group g (0..10) sits at byte address 0x10*g, with four words: status at +0x0, mask at +0x4, identity at +0x8 and enable at +0xC. The groups in order are engine 0 to 3, display pipes A to C, display port, display misc, south bridge and power unit. The master register is at 0xB0, address bits 1:0 are ignored, and every other address reads as zero.
- R2: On a clock edge where event bit i of group g is 1 and mask bit i holds 0 (the value before that edge), identity bit i becomes 1. An event that arrives while masked is dropped and never appears later.
- R3: Writing the identity register clears each bit written as 1 and keeps each bit written as 0. If an unmasked event arrives on the same edge, that event still sets its bit.
- R4: A write to mask or enable replaces the whole register. Status always reads the present level of the group's event inputs, and writes to status change nothing.
- R5: After reset every mask reads 0xFFFFFFFF, and every identity and enable register and the master register read 0.
- R6: The master bits 30:0 are summaries of pending = identity AND enable, with this routing: bit 0 from engine 0 bits 15:0, bit 1 from engine 0 bits 31:16, bit 2 from engine 1 bits 15:0, bit 3 from engine 1 bits 31:16, bit 4 from engine 2 bits 15:0, bit 6 from engine 3 bits 15:0, bits 16/17/18 from all of pipes A/B/C, bit 20 from the port group, bit 22 from the misc group, bit 23 from the south group and bit 30 from the power group. Every other summary bit reads 0, and the summaries follow pending in the same cycle.
- R7: Writing the master register updates only bit 31, which is the global enable. Writes to bits 30:0 are ignored.
- R8: The ready level is bit 31 AND (any summary bit) AND (msi_ctrl == 0x0001). `msg_req` is high for exactly one cycle, in the cycle that follows the first cycle in which the ready level is 1 after being 0.
- R9: Any msi_ctrl value other than 0x0001 holds the ready level at 0. This includes an enable bit 0 that is clear, and any of bits 15:1 that are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| ev_in | input | 352 | Event inputs, 32 per group, group g at bits 32*g+31:32*g |
| msi_ctrl | input | 16 | Message control word |
| msg_req | output | 1 | Single-cycle message request pulse |

## Verification
The assertions run on every cycle. They check that a request never lasts longer than one cycle, and that it never appears unless the global enable, a summary bit and the accepted control word were all present in the cycle before. They also check that no identity bit rises without an unmasked event on the previous edge, and that the global enable changes only after a write to the master address.

The exact routing of each group half, the write-one-to-clear rule when an event arrives on the same edge, the ignored writes to status and master, and the reset values can only be shown by the bench's scenarios. There a behavioural model is compared against the read port and the request every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_GROUPS = 11;
    localparam int SUMM_BITS  = DATA_W - 1;
    localparam int GRP_W      = $clog2(NUM_GROUPS + 1);
    localparam int CTRL_W     = 16;

    typedef enum logic [1:0] {
        OFF_STATUS = 2'd0,
        OFF_MASK   = 2'd1,
        OFF_IDEN   = 2'd2,
        OFF_EN     = 2'd3
    } reg_off_e;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] iden;
        logic [DATA_W-1:0] en;
    } leaf_regs_t;

    typedef struct packed {
        logic              vld;
        logic [GRP_W-1:0]  grp;
        logic [DATA_W-1:0] bits;
    } route_t;

    localparam logic [DATA_W-1:0] LO_HALF = 32'h0000_FFFF;
    localparam logic [DATA_W-1:0] HI_HALF = 32'hFFFF_0000;
    localparam logic [DATA_W-1:0] ALL_BITS = 32'hFFFF_FFFF;

    // Routing of group pending vectors onto master summary bits
    function automatic route_t route_of(input int b);
        route_t r;
        r = '0;
        case (b)
            0:  r = '{1'b1, GRP_W'(0),  LO_HALF};
            1:  r = '{1'b1, GRP_W'(0),  HI_HALF};
            2:  r = '{1'b1, GRP_W'(1),  LO_HALF};
            3:  r = '{1'b1, GRP_W'(1),  HI_HALF};
            4:  r = '{1'b1, GRP_W'(2),  LO_HALF};
            6:  r = '{1'b1, GRP_W'(3),  LO_HALF};
            16: r = '{1'b1, GRP_W'(4),  ALL_BITS};
            17: r = '{1'b1, GRP_W'(5),  ALL_BITS};
            18: r = '{1'b1, GRP_W'(6),  ALL_BITS};
            20: r = '{1'b1, GRP_W'(7),  ALL_BITS};
            22: r = '{1'b1, GRP_W'(8),  ALL_BITS};
            23: r = '{1'b1, GRP_W'(9),  ALL_BITS};
            30: r = '{1'b1, GRP_W'(10), ALL_BITS};
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/irq_leaf_group.sv
module irq_leaf_group
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ev_i,
    input  logic              wr_i,
    input  reg_off_e          off_i,
    input  logic [DATA_W-1:0] wdata_i,
    output leaf_regs_t        regs_o
);
    leaf_regs_t regs_d, regs_q;

    always_comb begin
        logic [DATA_W-1:0] clr;
        regs_d = regs_q;
        clr    = '0;
        if (wr_i) begin
            case (off_i)
                OFF_MASK: regs_d.mask = wdata_i;
                OFF_EN:   regs_d.en   = wdata_i;
                OFF_IDEN: clr         = wdata_i;
                default:  ;
            endcase
        end
        // capture uses the mask held before this edge; new events beat clears
        regs_d.iden = (regs_q.iden & ~clr) | (ev_i & ~regs_q.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.mask <= '1;
            regs_q.iden <= '0;
            regs_q.en   <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_agg_pkg::*;
(
    input  logic [DATA_W-1:0]    pend_i [NUM_GROUPS],
    output logic [SUMM_BITS-1:0] summ_o
);
    always_comb begin
        summ_o = '0;
        for (int b = 0; b < SUMM_BITS; b++) begin
            route_t r;
            r = route_of(b);
            if (r.vld) begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (r.grp == GRP_W'(g)) summ_o[b] = |(pend_i[g] & r.bits);
                end
            end
        end
    end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
    import irq_agg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gen_en_i,
    input  logic [SUMM_BITS-1:0] summ_i,
    input  logic [CTRL_W-1:0]    ctrl_i,
    output logic                 req_o
);
    localparam logic [CTRL_W-1:0] CTRL_OK = CTRL_W'(1);

    typedef struct packed {
        logic lvl;
        logic req;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        logic ready;
        ready    = gen_en_i && (|summ_i) && (ctrl_i == CTRL_OK);
        st_d.lvl = ready;
        st_d.req = ready && !st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data,
    input  logic [NUM_GROUPS*DATA_W-1:0] ev_in,
    input  logic [CTRL_W-1:0]            msi_ctrl,
    output logic                         msg_req
);
    localparam int OFF_LSB = 2;
    localparam int GRP_LSB = 4;
    localparam int TOP_LSB = GRP_LSB + GRP_W;

    typedef struct packed {
        logic gen_en;
    } master_t;

    logic [GRP_W-1:0]            grp_idx;
    reg_off_e                    off;
    logic                        hi_ok;
    leaf_regs_t                  regs [NUM_GROUPS];
    logic [DATA_W-1:0]           pend [NUM_GROUPS];
    logic [SUMM_BITS-1:0]        summ;
    logic [NUM_GROUPS*DATA_W-1:0] iden_flat;
    logic [NUM_GROUPS*DATA_W-1:0] mask_flat;
    master_t                     master_d, master_q;

    assign grp_idx = addr[TOP_LSB-1:GRP_LSB];
    assign off     = reg_off_e'(addr[GRP_LSB-1:OFF_LSB]);
    assign hi_ok   = (ADDR_W <= TOP_LSB) ? 1'b1 : ((addr >> TOP_LSB) == '0);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        irq_leaf_group u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_i    (ev_in[g*DATA_W +: DATA_W]),
            .wr_i    (wr_en && hi_ok && (grp_idx == GRP_W'(g))),
            .off_i   (off),
            .wdata_i (wr_data),
            .regs_o  (regs[g])
        );
        assign pend[g]                          = regs[g].iden & regs[g].en;
        assign iden_flat[g*DATA_W +: DATA_W]    = regs[g].iden;
        assign mask_flat[g*DATA_W +: DATA_W]    = regs[g].mask;
    end

    irq_route u_route (
        .pend_i (pend),
        .summ_o (summ)
    );

    always_comb begin
        master_d = master_q;
        if (wr_en && hi_ok && grp_idx == GRP_W'(NUM_GROUPS) && off == OFF_STATUS)
            master_d.gen_en = wr_data[DATA_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) master_q <= '0;
        else        master_q <= master_d;
    end

    irq_req_gen u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_en_i (master_q.gen_en),
        .summ_i   (summ),
        .ctrl_i   (msi_ctrl),
        .req_o    (msg_req)
    );

    always_comb begin
        rd_data = '0;
        if (hi_ok) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (grp_idx == GRP_W'(g)) begin
                    case (off)
                        OFF_STATUS: rd_data = ev_in[g*DATA_W +: DATA_W];
                        OFF_MASK:   rd_data = regs[g].mask;
                        OFF_IDEN:   rd_data = regs[g].iden;
                        default:    rd_data = regs[g].en;
                    endcase
                end
            end
            if (grp_idx == GRP_W'(NUM_GROUPS) && off == OFF_STATUS)
                rd_data = {master_q.gen_en, summ};
        end
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [NUM_GROUPS*DATA_W-1:0] ev_in,
    input logic [CTRL_W-1:0]            msi_ctrl,
    input logic                         msg_req,
    input logic                         gen_en,
    input logic [SUMM_BITS-1:0]         summ,
    input logic [NUM_GROUPS*DATA_W-1:0] iden_flat,
    input logic [NUM_GROUPS*DATA_W-1:0] mask_flat
);
    localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(NUM_GROUPS * 16);

    assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |=> !msg_req);

    assert_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> $past(gen_en && (|summ) && (msi_ctrl == 16'h0001)));

    assert_no_masked_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((iden_flat & ~$past(iden_flat)) & ~$past(ev_in & ~mask_flat)) == '0);

    assert_enable_by_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gen_en) |-> $past(wr_en && (addr[ADDR_W-1:2] == MASTER_ADDR[ADDR_W-1:2])));
endmodule

bind irq_aggregator irq_aggregator_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .ev_in     (ev_in),
    .msi_ctrl  (msi_ctrl),
    .msg_req   (msg_req),
    .gen_en    (master_q.gen_en),
    .summ      (summ),
    .iden_flat (iden_flat),
    .mask_flat (mask_flat)
);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
    localparam int NG = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NG*32-1:0] ev = '0;
    logic [15:0]   msi = '0;
    logic          msg_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string tag = "R5";

    logic [31:0] m_mask [NG];
    logic [31:0] m_iden [NG];
    logic [31:0] m_en   [NG];
    bit m_gen, m_lvl, m_req;

    always #4 clk = ~clk;

    irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .ev_in(ev),
        .msi_ctrl(msi), .msg_req(msg_req)
    );

    function automatic logic [30:0] ref_summ();
        logic [31:0] p [NG];
        logic [30:0] s;
        for (int g = 0; g < NG; g++) p[g] = m_iden[g] & m_en[g];
        s = '0;
        s[0]  = |p[0][15:0];  s[1] = |p[0][31:16];
        s[2]  = |p[1][15:0];  s[3] = |p[1][31:16];
        s[4]  = |p[2][15:0];  s[6] = |p[3][15:0];
        s[16] = |p[4]; s[17] = |p[5]; s[18] = |p[6];
        s[20] = |p[7]; s[22] = |p[8]; s[23] = |p[9]; s[30] = |p[10];
        return s;
    endfunction

    function automatic logic [31:0] ref_read(input logic [7:0] a);
        int g = a[7:4];
        int o = a[3:2];
        if (g < NG) begin
            if (o == 0) return ev[g*32 +: 32];
            if (o == 1) return m_mask[g];
            if (o == 2) return m_iden[g];
            return m_en[g];
        end
        if (g == NG && o == 0) return {m_gen, ref_summ()};
        return 32'h0;
    endfunction

    task automatic model_reset();
        for (int g = 0; g < NG; g++) begin
            m_mask[g] = '1; m_iden[g] = '0; m_en[g] = '0;
        end
        m_gen = 0; m_lvl = 0; m_req = 0;
    endtask

    task automatic model_edge();
        bit lvl;
        int g, o;
        logic [31:0] clr;
        lvl   = m_gen && (ref_summ() != 0) && (msi == 16'h0001);
        m_req = lvl && !m_lvl;
        m_lvl = lvl;
        g = addr[7:4];
        o = addr[3:2];
        if (wr_en && g == NG && o == 0) m_gen = wr_data[31];
        for (int k = 0; k < NG; k++) begin
            logic [31:0] oldmask;
            oldmask = m_mask[k];
            clr = '0;
            if (wr_en && g == k) begin
                if (o == 1) m_mask[k] = wr_data;
                if (o == 3) m_en[k]   = wr_data;
                if (o == 2) clr       = wr_data;
            end
            m_iden[k] = (m_iden[k] & ~clr) | (ev[k*32 +: 32] & ~oldmask);
        end
    endtask

    task automatic compare();
        logic [31:0] exp_rd;
        exp_rd = ref_read(addr);
        checks++;
        if (rd_data !== exp_rd) begin
            errors++;
            $display("FAIL %s rd_data addr=%h actual=%h expected=%h", tag, addr, rd_data, exp_rd);
        end
        checks++;
        if (msg_req !== m_req) begin
            errors++;
            $display("FAIL %s msg_req actual=%b expected=%b", tag, msg_req, m_req);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        if (rst_n) model_edge(); else model_reset();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wr_data = d;
        cyc();
        wr_en = 0; wr_data = '0;
    endtask

    task automatic rd(input logic [7:0] a);
        addr = a;
        cyc();
    endtask

    task automatic pulse(input int g, input int b);
        ev[g*32 + b] = 1'b1;
        cyc();
        ev[g*32 + b] = 1'b0;
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        repeat (3) cyc();
        rst_n = 1;
        // R5: reset values of every group and the master register
        tag = "R5";
        for (int g = 0; g < NG; g++) begin
            rd(8'(g*16 + 4)); rd(8'(g*16 + 8)); rd(8'(g*16 + 12));
        end
        rd(8'hB0);
        // R1: unmapped addresses read zero
        tag = "R1";
        rd(8'hB4); rd(8'hC0); rd(8'hFC); rd(8'h0D);
        // R2: masked event dropped, stays dropped after unmask
        tag = "R2";
        pulse(4, 0);
        rd(8'h48);
        wr(8'h44, 32'h0);
        rd(8'h48);
        pulse(4, 0);
        rd(8'h48);
        // R8: engine 0 render event raises one request pulse
        tag = "R8";
        msi = 16'h0001;
        wr(8'h04, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'hB0, 32'h8000_0000);
        addr = 8'hB0;
        pulse(0, 0);
        repeat (4) cyc();
        // R6: blitter half routes to summary bit 1, pipe A to bit 16
        tag = "R6";
        pulse(0, 16);
        rd(8'hB0);
        wr(8'h4C, 32'h0000_0001);
        rd(8'hB0);
        wr(8'h24, 32'h0);
        wr(8'h2C, 32'hFFFF_FFFF);
        pulse(2, 20);
        rd(8'hB0);
        pulse(2, 3);
        rd(8'hB0);
        wr(8'hA4, 32'h0); wr(8'hAC, 32'h0200_0000);
        pulse(10, 25);
        rd(8'hB0);
        // R3: write-one-to-clear, and event wins over same-edge clear
        tag = "R3";
        wr(8'h08, 32'h0000_0001);
        rd(8'h08);
        ev[0] = 1'b1;
        wr(8'h08, 32'hFFFF_FFFF);
        ev[0] = 1'b0;
        rd(8'h08);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h48, 32'hFFFF_FFFF);
        wr(8'hA8, 32'hFFFF_FFFF);
        rd(8'hB0);
        // R4: status shows live level and ignores writes
        tag = "R4";
        ev[3*32 +: 32] = 32'hA5A5_0F0F;
        rd(8'h30);
        wr(8'h30, 32'h0);
        rd(8'h30);
        ev[3*32 +: 32] = '0;
        rd(8'h30);
        wr(8'h34, 32'h1234_5678);
        rd(8'h34);
        // R7: only bit 31 of master is writable
        tag = "R7";
        wr(8'hB0, 32'h7FFF_FFFF);
        rd(8'hB0);
        wr(8'hB3, 32'hFFFF_FFFF);
        rd(8'hB0);
        // R9: bad control words suppress the request
        tag = "R9";
        msi = 16'h0003;
        addr = 8'hB0;
        pulse(0, 4);
        repeat (3) cyc();
        msi = 16'h0000;
        repeat (2) cyc();
        tag = "R8";
        msi = 16'h0001;
        repeat (4) cyc();
        // R8: global enable off then on re-arms the pulse
        wr(8'hB0, 32'h0);
        repeat (2) cyc();
        wr(8'hB0, 32'h8000_0000);
        repeat (4) cyc();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R8 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule